// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a three-wire link to a serial sampling analog-to-digital converter. It divides the system clock down to make the serial clock. It raises the convert strobe to start each conversion, and it shifts in the result that the converter returns on its data line during the clocks that follow. The word that arrives in a frame belongs to the conversion started one frame earlier, because the converter holds the new input while it streams out the previous result. The block sign-extends the captured two's complement word to a fixed output width and presents it with a one-cycle valid strobe and a flag that says whether the word comes from a sample that was actually requested.

A frame is eighteen serial clocks: sixteen data clocks followed by two clocks that give the converter time to acquire the next input. With the enable input held high, frames run back to back. With enable low, each pulse on the trigger input runs exactly one frame. A trigger that arrives while a frame is in progress is kept and runs the following frame. Parameters select a 12-bit or 14-bit result, the serial clock divide ratio, and a capture window shifted one clock late for links where the convert-to-clock setup is too short.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset, with enable and trigger low, the serial clock, the convert strobe and the valid strobe are all low.
- R2: The convert strobe rises while the serial clock is low, DIV system cycles before the first serial clock rising edge, and falls together with the first serial clock falling edge, so it stays high for 2*DIV system cycles.
- R3: Each frame has exactly 18 serial clock rising edges, each serial clock level lasts DIV system cycles, and with enable held high the next convert strobe rises at the falling edge after the 18th rise, giving 36*DIV system cycles between conversions.
- R4: With SKEW = 0 the bit the converter puts out after serial rise k (k = 1 to RES) is captured at rise k+1; the first bit is the most significant, and the word is read as two's complement and sign-extended to the OUT_W-bit sample output.
- R5: With RES = 12 the data line bits that follow the least significant bit within the sixteen data clocks have no effect on the sample.
- R6: With SKEW = 1 the capture window moves one serial clock later: the bit put out after rise k+1 is captured at rise k+2.
- R7: The valid strobe is high for exactly one system cycle per frame.
- R8: The sample delivered in a frame equals the converter output code of the input held at the start of the previous frame.
- R9: The freshness flag is 0 on the first valid strobe after reset and 1 on every later one.
- R10: With enable low and no trigger the serial clock and convert strobe stay low; each trigger pulse runs exactly one frame, and a trigger arriving during a frame runs one more frame after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | High: frames run back to back |
| trig | input | 1 | One-cycle pulse requesting a single frame |
| sdo | input | 1 | Serial data from the converter |
| sck | output | 1 | Serial clock to the converter |
| conv | output | 1 | Convert strobe to the converter |
| sample | output | OUT_W | Sign-extended result word |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |
| sample_fresh | output | 1 | Sample comes from a requested conversion |

## Verification
The hardest condition to reach from the ports is every result code, including the sign boundaries, passing through the one-frame-late pipeline while the trailing ignored bits are driven to the opposite level. The bench models the converter as a shift register that returns the code held at the previous convert edge and drives ones after the last data bit; in continuous mode it steps the 12-bit instance through all 4096 codes with an odd stride after the four extreme codes. A trigger is also placed in the middle of a single-shot frame, which is the only way to exercise the deferred-trigger path.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int RES   = 14,
  parameter int DIV   = 2,
  parameter int SKEW  = 0,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trig,
  input  logic             sdo,
  output logic             sck,
  output logic             conv,
  output logic [OUT_W-1:0] sample,
  output logic             sample_vld,
  output logic             sample_fresh
);
  localparam int DATA_CLKS = 16;
  localparam int ACQ_CLKS  = 2;
  localparam int FRAME     = DATA_CLKS + ACQ_CLKS;
  localparam int FIRST_CAP = 2 + SKEW;
  localparam int LAST_CAP  = RES + 1 + SKEW;
  localparam int PW        = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EW        = $clog2(FRAME + 1);

  logic [PW-1:0]  ph;
  logic [EW-1:0]  ecnt;
  logic           busy, pend, primed;
  logic [RES-1:0] sr;

  wire [RES-1:0] word  = {sr[RES-2:0], sdo};
  wire [EW-1:0]  enx   = ecnt + 1'b1;
  wire           ph_end = (ph == PW'(DIV - 1));
  wire           rise  = busy && ph_end && !sck;
  wire           fall  = busy && ph_end && sck;
  wire           go    = en || trig || pend;
  wire           cap   = rise && (enx >= EW'(FIRST_CAP)) && (enx <= EW'(LAST_CAP));
  wire           done  = rise && (enx == EW'(LAST_CAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; ecnt <= '0; busy <= 1'b0; pend <= 1'b0; primed <= 1'b0;
      sck <= 1'b0; conv <= 1'b0; sr <= '0;
      sample <= '0; sample_vld <= 1'b0; sample_fresh <= 1'b0;
    end else begin
      sample_vld <= 1'b0;
      if (trig) pend <= 1'b1;
      if (cap) sr <= word;
      if (done) begin
        sample       <= {{(OUT_W-RES){word[RES-1]}}, word};
        sample_vld   <= 1'b1;
        sample_fresh <= primed;
        primed       <= 1'b1;
      end
      if (!busy) begin
        if (go) begin
          busy <= 1'b1; conv <= 1'b1; ecnt <= '0; ph <= '0; pend <= 1'b0;
        end
      end else if (ph_end) begin
        ph  <= '0;
        sck <= ~sck;
        if (rise) ecnt <= enx;
        if (fall) begin
          if (ecnt == EW'(1)) conv <= 1'b0;
          if (ecnt == EW'(FRAME)) begin
            if (go) begin
              conv <= 1'b1; ecnt <= '0; pend <= 1'b0;
            end else begin
              busy <= 1'b0;
            end
          end
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  logic        sck_d, conv_d, seen;
  logic [EW-1:0] rises;
  logic [15:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0; conv_d <= 1'b0; seen <= 1'b0; rises <= '0; hold <= '0;
    end else begin
      sck_d  <= sck;
      conv_d <= conv;
      hold   <= (sck != sck_d) ? 16'd1 : ((hold == 16'hFFFF) ? hold : hold + 16'd1);
      if (conv && !conv_d) begin
        rises <= '0;
        seen  <= 1'b1;
      end else if (sck && !sck_d && rises != '1) begin
        rises <= rises + 1'b1;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !conv));
  a_r2_conv_leads_sck: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) && rises == '0) |-> conv);
  a_r2_conv_drops_with_sck: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv) |-> $fell(sck));
  a_r3_eighteen_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> (!seen || rises == EW'(FRAME)));
  a_r3_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hold == 16'(DIV)));
  a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) && rises != '0) |-> (hold == 16'(DIV)));
  a_r7_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);
endmodule

// File: tb/sim_adc_frame_reader.sv
module conv_model #(
  parameter int RES  = 14,
  parameter int SKEW = 0,
  parameter int STEP = 97
) (
  input  logic           sck,
  input  logic           conv,
  output logic           sdo,
  output logic [RES-1:0] out_word
);
  int convs, last, k, n;
  logic [RES-1:0] held;

  function automatic logic [RES-1:0] gen(input int i);
    if (i == 0) return {1'b0, {(RES-1){1'b1}}};
    if (i == 1) return {1'b1, {(RES-1){1'b0}}};
    if (i == 2) return '1;
    if (i == 3) return '0;
    return RES'(i * STEP);
  endfunction

  initial begin
    sdo = 1'b0; out_word = '0; held = '0; convs = 0; last = 0; k = 0; n = 0;
  end

  always @(posedge conv) begin
    out_word = held;
    held     = gen(n);
    n        = n + 1;
    convs    = convs + 1;
  end

  always @(posedge sck) begin
    if (convs != last) begin
      last = convs;
      k = 1;
    end else begin
      k = k + 1;
    end
    if (k >= 1 + SKEW && k <= RES + SKEW) sdo <= out_word[RES-(k-SKEW)];
    else sdo <= 1'b1;
  end
endmodule

module frame_mon #(
  parameter int    RES = 14,
  parameter int    DIV = 2,
  parameter string TAG = "R4"
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cont,
  input  logic           sck,
  input  logic           conv,
  input  logic           vld,
  input  logic           fresh,
  input  logic [15:0]    dout,
  input  logic [RES-1:0] exp_word,
  output int             nchk,
  output int             nbad,
  output int             nvld,
  output int             nconv
);
  int cyc, rises;
  logic sck_p, conv_p, vld_p;
  logic [15:0] expv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", TAG, req, act, exp);
    end
  endtask

  initial begin
    nchk = 0; nbad = 0; nvld = 0; nconv = 0; cyc = 0; rises = 0;
    sck_p = 0; conv_p = 0; vld_p = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (conv && !conv_p) begin
        nconv++;
        if (cont && nconv > 1) begin
          chk(cyc == 36 * DIV, "R3 conversion spacing", cyc, 36 * DIV);
          chk(rises == 18, "R3 clocks per frame", rises, 18);
        end
        cyc = 0;
        rises = 0;
      end
      if (!conv && conv_p) chk(cyc == 2 * DIV, "R2 convert width", cyc, 2 * DIV);
      if (sck && !sck_p) begin
        rises++;
        if (rises == 1) chk(cyc == DIV, "R2 convert lead", cyc, DIV);
      end
      if (vld) begin
        nvld++;
        if (vld_p) chk(1'b0, "R7 valid longer than one cycle", 2, 1);
        expv = {{(16-RES){exp_word[RES-1]}}, exp_word};
        if (nvld == 1) begin
          chk(fresh == 1'b0, "R9 first word flag", int'(fresh), 0);
        end else begin
          chk(fresh == 1'b1, "R9 later word flag", int'(fresh), 1);
          chk(dout == expv, "R8 previous-sample value", int'(dout), int'(expv));
        end
      end
      sck_p = sck; conv_p = conv; vld_p = vld;
    end
  end
endmodule

module sim_adc_frame_reader;
  logic clk = 1'b0;
  logic rst_n, en, trig, cont;
  always #5 clk = ~clk;

  logic sck0, conv0, sdo0, vld0, fr0;
  logic sck1, conv1, sdo1, vld1, fr1;
  logic [15:0] s0, s1;
  logic [13:0] w0;
  logic [11:0] w1;
  int c0, b0, v0, k0, c1, b1, v1, k1;
  int nchk = 0, nbad = 0;
  bit over = 0;

  // u0: 14-bit, capture per R4; u1: 12-bit with trailing junk (R5) and late window (R6)
  adc_frame_reader #(.RES(14), .DIV(2), .SKEW(0), .OUT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .sdo(sdo0),
    .sck(sck0), .conv(conv0), .sample(s0), .sample_vld(vld0), .sample_fresh(fr0));
  adc_frame_reader #(.RES(12), .DIV(1), .SKEW(1), .OUT_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .sdo(sdo1),
    .sck(sck1), .conv(conv1), .sample(s1), .sample_vld(vld1), .sample_fresh(fr1));

  conv_model #(.RES(14), .SKEW(0), .STEP(97)) m0 (.sck(sck0), .conv(conv0), .sdo(sdo0), .out_word(w0));
  conv_model #(.RES(12), .SKEW(1), .STEP(1029)) m1 (.sck(sck1), .conv(conv1), .sdo(sdo1), .out_word(w1));

  frame_mon #(.RES(14), .DIV(2), .TAG("R4")) mon0 (
    .clk(clk), .rst_n(rst_n), .cont(cont), .sck(sck0), .conv(conv0), .vld(vld0),
    .fresh(fr0), .dout(s0), .exp_word(w0), .nchk(c0), .nbad(b0), .nvld(v0), .nconv(k0));
  frame_mon #(.RES(12), .DIV(1), .TAG("R5 R6")) mon1 (
    .clk(clk), .rst_n(rst_n), .cont(cont), .sck(sck1), .conv(conv1), .vld(vld1),
    .fresh(fr1), .dout(s1), .exp_word(w1), .nchk(c1), .nbad(b1), .nvld(v1), .nconv(k1));

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk + c0 + c1, nbad + b0 + b1);
      $finish;
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int sv0, sv1, sk0, sk1;
    rst_n = 1'b0; en = 1'b0; trig = 1'b0; cont = 1'b1;
    repeat (4) @(negedge clk);
    chk(sck0 == 0 && sck1 == 0, "R1 clock low in reset", int'(sck0 | sck1), 0);
    chk(conv0 == 0 && conv1 == 0, "R1 convert low in reset", int'(conv0 | conv1), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sck0 == 0 && sck1 == 0, "R1 clock low after reset", int'(sck0 | sck1), 0);
    chk(conv0 == 0 && conv1 == 0, "R1 convert low after reset", int'(conv0 | conv1), 0);
    chk(vld0 == 0 && vld1 == 0, "R1 valid low after reset", int'(vld0 | vld1), 0);
    // continuous run: u1 walks every 12-bit code (R5, R6, R8)
    en = 1'b1;
    while (v1 < 4102) @(negedge clk);
    chk(v0 > 2000, "R3 u0 frame count", v0, 2001);
    // single-shot section (R10)
    en = 1'b0; cont = 1'b0;
    repeat (300) @(negedge clk);
    sv0 = v0; sv1 = v1; sk0 = k0; sk1 = k1;
    repeat (300) @(negedge clk);
    chk(v0 == sv0 && v1 == sv1, "R10 no words while idle", v0 + v1, sv0 + sv1);
    chk(sck0 == 0 && sck1 == 0 && conv0 == 0 && conv1 == 0, "R10 idle outputs low",
        int'(sck0 | sck1 | conv0 | conv1), 0);
    pulse_trig();
    repeat (200) @(negedge clk);
    chk(k0 == sk0 + 1 && k1 == sk1 + 1, "R10 one frame per trigger", k0 + k1, sk0 + sk1 + 2);
    chk(v0 == sv0 + 1 && v1 == sv1 + 1, "R10 one word per trigger", v0 + v1, sv0 + sv1 + 2);
    pulse_trig();
    repeat (20) @(negedge clk);
    pulse_trig();
    repeat (300) @(negedge clk);
    chk(k0 == sk0 + 3 && k1 == sk1 + 3, "R10 trigger during frame deferred", k0 + k1, sk0 + sk1 + 6);
    chk(v0 == sv0 + 3 && v1 == sv1 + 3, "R10 words after deferred trigger", v0 + v1, sv0 + sv1 + 6);
    chk(sck0 == 0 && sck1 == 0, "R10 clock parked low", int'(sck0 | sck1), 0);
    finish_run();
  end
endmodule